// File: doc/BRIEF.md
# Queued Semaphore Request Arbiter

This block serves the interrupt-driven request path of a bank of shared hardware semaphores used by several processor cores. A core asks for a semaphore by writing to it. The write takes effect whether the semaphore is free or taken, and the core never learns the outcome through the bus. A free semaphore goes to the writer at once. A taken semaphore puts the writer into a first-in-first-out waiting list that belongs to that semaphore. When the owner gives the semaphore up, it passes straight to the core that has waited longest. The winning core learns that it now holds the semaphore from an interrupt line of its own.

Each core has a latched grant interrupt and a vector that marks which semaphores it has been handed since it last cleared them. The block catches misuse and reports it as a one-cycle error record with a code, the semaphore and the core. The misuse cases are a repeated request from a core that is already waiting, a request from the current holder, a release by a core that is not the holder, and a release of a semaphore that nobody holds. Address decoding comes before this block and is not part of it. So is the polling read path.

Top module: `sem_queue_arbiter`

## Requirements
- R1: After reset every semaphore is free (`sem_busy` all zero), every waiting list is empty, `grant_irq` and `grant_status` are all zero and `err_valid` is low.
- R2: A request (`wr_valid`=1, `wr_free`=0) for a free semaphore makes the writer its owner at that clock edge. From the same edge, `sem_busy[s]` is 1, `sem_owner[s*CORE_W +: CORE_W]` equals the writer, `grant_irq[core]` is 1 and `grant_status[core*NUM_SEMS+s]` is 1.
- R3: A request from a core that neither owns the semaphore nor is waiting for it appends that core to the semaphore's waiting list. The owner does not change and no grant is raised.
- R4: A release (`wr_valid`=1, `wr_free`=1) by the owner while cores are waiting hands ownership to the head of the list at that edge, with no cycle in which the semaphore is free. The new owner's grant interrupt and status bit are set.
- R5: A release by the owner while no core is waiting sets `sem_busy[s]` to 0.
- R6: Waiting cores receive a semaphore strictly in the order in which their requests arrived. Up to NUM_CORES-1 cores can wait on one semaphore.
- R7: A request from a core already on the semaphore's waiting list reports error code 4. The core is not added a second time and nothing else changes.
- R8: A request from the current owner reports error code 3 and changes nothing.
- R9: A release by a core other than the owner reports error code 2. A release of a free semaphore reports error code 1. Neither changes any owner or waiting list.
- R10: `grant_irq[c]` stays high until a cycle in which `irq_clr[c]` is 1. That cycle also clears core c's row of `grant_status`. A grant to core c at the same edge overrides the clear and sets both again.
- R11: After an erroneous write, `err_valid` is high for exactly the following cycle, with `err_code`, `err_sem` and `err_core` naming the code, the semaphore and the writer. After any other cycle `err_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One decoded write to a semaphore this cycle |
| wr_core | input | CORE_W | Core issuing the write |
| wr_sem | input | SEM_W | Target semaphore index, below NUM_SEMS |
| wr_free | input | 1 | 1 = release, 0 = request |
| irq_clr | input | NUM_CORES | Per-core clear of grant interrupt and status row |
| grant_irq | output | NUM_CORES | Latched per-core grant interrupt |
| grant_status | output | NUM_CORES*NUM_SEMS | Bit c*NUM_SEMS+s: core c was granted semaphore s |
| sem_busy | output | NUM_SEMS | Semaphore currently held |
| sem_owner | output | NUM_SEMS*CORE_W | Owner id of each semaphore, valid when busy |
| err_valid | output | 1 | Error record valid for one cycle |
| err_code | output | 3 | 1 already free, 2 wrong releaser, 3 already held, 4 already waiting |
| err_sem | output | SEM_W | Semaphore of the erroneous write |
| err_core | output | CORE_W | Core of the erroneous write |

## Verification
A corrupted waiting list shows up at the ports only at the next release of that semaphore. At that point ownership goes to the wrong core, or the semaphore turns free while cores are still waiting. A stale membership bit shows up sooner, as a false or missing code-4 error on the very next request from that core. The bench therefore releases every semaphore completely after each round of requests. It also compares owner, grant and error outputs with a model after every single cycle, so a fault is caught within one release of where it first appears.

// File: rtl/sem_arb_pkg.sv
package sem_arb_pkg;

    typedef enum logic [2:0] {
        ERR_NONE         = 3'd0,
        ERR_ALREADY_FREE = 3'd1,
        ERR_WRONG_OWNER  = 3'd2,
        ERR_ALREADY_HELD = 3'd3,
        ERR_ALREADY_WAIT = 3'd4
    } err_e;

endpackage

// File: rtl/sem_wait_fifo.sv
module sem_wait_fifo #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 pop,
    input  logic [CORE_W-1:0]    push_id,
    output logic                 empty,
    output logic [CORE_W-1:0]    head,
    output logic [NUM_CORES-1:0] member
);
    localparam int CNT_W = $clog2(NUM_CORES + 1);

    typedef struct packed {
        logic [NUM_CORES-1:0][CORE_W-1:0] slot;
        logic [CNT_W-1:0]                 cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < NUM_CORES - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[NUM_CORES-1] = '0;
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (push && st_q.cnt < CNT_W'(NUM_CORES)) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (CNT_W'(i) == st_q.cnt) begin
                    st_d.slot[i] = push_id;
                end
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        member = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (CNT_W'(i) < st_q.cnt) begin
                member[st_q.slot[i]] = 1'b1;
            end
        end
    end

    assign empty = (st_q.cnt == '0);
    assign head  = st_q.slot[0];

endmodule

// File: rtl/sem_grant_bank.sv
module sem_grant_bank #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEMS  = 4,
    parameter int CORE_W    = 2,
    parameter int SEM_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gnt_valid,
    input  logic [CORE_W-1:0]             gnt_core,
    input  logic [SEM_W-1:0]              gnt_sem,
    input  logic [NUM_CORES-1:0]          irq_clr,
    output logic [NUM_CORES-1:0]          grant_irq,
    output logic [NUM_CORES*NUM_SEMS-1:0] grant_status
);
    typedef struct packed {
        logic [NUM_CORES-1:0]               irq;
        logic [NUM_CORES-1:0][NUM_SEMS-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (irq_clr[c]) begin
                st_d.irq[c]  = 1'b0;
                st_d.stat[c] = '0;
            end
            if (gnt_valid && gnt_core == CORE_W'(c)) begin
                st_d.irq[c]           = 1'b1;
                st_d.stat[c][gnt_sem] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_irq    = st_q.irq;
    assign grant_status = st_q.stat;

endmodule

// File: rtl/sem_queue_arbiter.sv
module sem_queue_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEMS  = 4,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int SEM_W    = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [CORE_W-1:0]             wr_core,
    input  logic [SEM_W-1:0]              wr_sem,
    input  logic                          wr_free,
    input  logic [NUM_CORES-1:0]          irq_clr,
    output logic [NUM_CORES-1:0]          grant_irq,
    output logic [NUM_CORES*NUM_SEMS-1:0] grant_status,
    output logic [NUM_SEMS-1:0]           sem_busy,
    output logic [NUM_SEMS*CORE_W-1:0]    sem_owner,
    output logic                          err_valid,
    output logic [2:0]                    err_code,
    output logic [SEM_W-1:0]              err_sem,
    output logic [CORE_W-1:0]             err_core
);
    import sem_arb_pkg::*;

    typedef struct packed {
        logic [NUM_SEMS-1:0]              busy;
        logic [NUM_SEMS-1:0][CORE_W-1:0]  owner;
        logic                             err_valid;
        err_e                             err_code;
        logic [SEM_W-1:0]                 err_sem;
        logic [CORE_W-1:0]                err_core;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_SEMS-1:0]  q_push, q_pop, q_empty;
    logic [CORE_W-1:0]    q_head   [NUM_SEMS];
    logic [NUM_CORES-1:0] q_member [NUM_SEMS];
    logic [CORE_W-1:0]    q_push_id;

    logic                 gnt_valid;
    logic [CORE_W-1:0]    gnt_core;

    logic                 sel_busy, sel_empty;
    logic [CORE_W-1:0]    sel_owner, sel_head;
    logic [NUM_CORES-1:0] sel_member;

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_wait
        sem_wait_fifo #(
            .NUM_CORES (NUM_CORES),
            .CORE_W    (CORE_W)
        ) i_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (q_push[s]),
            .pop     (q_pop[s]),
            .push_id (q_push_id),
            .empty   (q_empty[s]),
            .head    (q_head[s]),
            .member  (q_member[s])
        );
    end

    always_comb begin
        sel_busy   = st_q.busy[wr_sem];
        sel_owner  = st_q.owner[wr_sem];
        sel_empty  = q_empty[wr_sem];
        sel_head   = q_head[wr_sem];
        sel_member = q_member[wr_sem];
    end

    always_comb begin
        st_d           = st_q;
        st_d.err_valid = 1'b0;
        q_push         = '0;
        q_pop          = '0;
        q_push_id      = wr_core;
        gnt_valid      = 1'b0;
        gnt_core       = wr_core;

        if (wr_valid) begin
            st_d.err_sem  = wr_sem;
            st_d.err_core = wr_core;
            if (!wr_free) begin
                if (!sel_busy) begin
                    st_d.busy[wr_sem]  = 1'b1;
                    st_d.owner[wr_sem] = wr_core;
                    gnt_valid          = 1'b1;
                end else if (sel_owner == wr_core) begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_ALREADY_HELD;
                end else if (sel_member[wr_core]) begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_ALREADY_WAIT;
                end else begin
                    q_push[wr_sem] = 1'b1;
                end
            end else begin
                if (!sel_busy) begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_ALREADY_FREE;
                end else if (sel_owner != wr_core) begin
                    st_d.err_valid = 1'b1;
                    st_d.err_code  = ERR_WRONG_OWNER;
                end else if (!sel_empty) begin
                    st_d.owner[wr_sem] = sel_head;
                    q_pop[wr_sem]      = 1'b1;
                    gnt_valid          = 1'b1;
                    gnt_core           = sel_head;
                end else begin
                    st_d.busy[wr_sem] = 1'b0;
                end
            end
            if (!st_d.err_valid) begin
                st_d.err_sem  = st_q.err_sem;
                st_d.err_core = st_q.err_core;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sem_grant_bank #(
        .NUM_CORES (NUM_CORES),
        .NUM_SEMS  (NUM_SEMS),
        .CORE_W    (CORE_W),
        .SEM_W     (SEM_W)
    ) i_grant (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt_valid    (gnt_valid),
        .gnt_core     (gnt_core),
        .gnt_sem      (wr_sem),
        .irq_clr      (irq_clr),
        .grant_irq    (grant_irq),
        .grant_status (grant_status)
    );

    assign sem_busy  = st_q.busy;
    assign sem_owner = st_q.owner;
    assign err_valid = st_q.err_valid;
    assign err_code  = st_q.err_code;
    assign err_sem   = st_q.err_sem;
    assign err_core  = st_q.err_core;

endmodule

// File: rtl/sem_queue_arbiter_chk.sv
module sem_queue_arbiter_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SEMS  = 4,
    parameter int CORE_W    = 2,
    parameter int SEM_W     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic [CORE_W-1:0]          wr_core,
    input logic [SEM_W-1:0]           wr_sem,
    input logic                       wr_free,
    input logic [NUM_CORES-1:0]       irq_clr,
    input logic [NUM_CORES-1:0]       grant_irq,
    input logic [NUM_SEMS-1:0]        sem_busy,
    input logic [NUM_SEMS*CORE_W-1:0] sem_owner,
    input logic                       err_valid,
    input logic [NUM_SEMS-1:0]        q_empty
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            grant_irq[c] && !irq_clr[c] |=> grant_irq[c]); // R10
    end

    for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem
        AST_FREE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            !sem_busy[s] |-> q_empty[s]); // R5
    end

    AST_ONE_NEW_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_irq & ~$past(grant_irq))); // R2

    AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (sem_busy == $past(sem_busy)) && (sem_owner == $past(sem_owner))); // R11

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !err_valid); // R11

    AST_HANDOVER_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_free && sem_busy[wr_sem] && !q_empty[wr_sem]
        && sem_owner[wr_sem*CORE_W +: CORE_W] == wr_core
        |=> sem_busy[$past(wr_sem)]); // R4

endmodule

bind sem_queue_arbiter sem_queue_arbiter_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_SEMS  (NUM_SEMS),
    .CORE_W    (CORE_W),
    .SEM_W     (SEM_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_core   (wr_core),
    .wr_sem    (wr_sem),
    .wr_free   (wr_free),
    .irq_clr   (irq_clr),
    .grant_irq (grant_irq),
    .sem_busy  (sem_busy),
    .sem_owner (sem_owner),
    .err_valid (err_valid),
    .q_empty   (q_empty)
);

// File: tb/test_sem_queue_arbiter.sv
`timescale 1ns/1ps
module test_sem_queue_arbiter;
    localparam int NC = 4;
    localparam int NS = 4;
    localparam int CW = 2;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [CW-1:0] wr_core = '0;
    logic [SW-1:0] wr_sem = '0;
    logic          wr_free = 1'b0;
    logic [NC-1:0] irq_clr = '0;
    logic [NC-1:0] grant_irq;
    logic [NC*NS-1:0] grant_status;
    logic [NS-1:0] sem_busy;
    logic [NS*CW-1:0] sem_owner;
    logic          err_valid;
    logic [2:0]    err_code;
    logic [SW-1:0] err_sem;
    logic [CW-1:0] err_core;

    always #2 clk = ~clk;

    sem_queue_arbiter #(.NUM_CORES(NC), .NUM_SEMS(NS)) i_sem_queue_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_core(wr_core),
        .wr_sem(wr_sem), .wr_free(wr_free), .irq_clr(irq_clr),
        .grant_irq(grant_irq), .grant_status(grant_status), .sem_busy(sem_busy),
        .sem_owner(sem_owner), .err_valid(err_valid), .err_code(err_code),
        .err_sem(err_sem), .err_core(err_core));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_busy [NS];
    int m_owner[NS];
    int m_q    [NS][NC];
    int m_cnt  [NS];
    int m_irq  [NC];
    int m_stat [NC][NS];
    int e_err, e_code, e_sem, e_core;
    string tag;

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input int c, input int s, input bit f,
                         input logic [NC-1:0] clr);
        bool_t_dummy();
        e_err = 0;
        tag = "R3";
        for (int k = 0; k < NC; k++) begin
            if (clr[k]) begin
                m_irq[k] = 0;
                for (int j = 0; j < NS; j++) m_stat[k][j] = 0;
            end
        end
        if (!v) return;
        if (!f) begin
            if (!m_busy[s]) begin
                m_busy[s] = 1; m_owner[s] = c; m_irq[c] = 1; m_stat[c][s] = 1;
                tag = "R2";
            end else if (m_owner[s] == c) begin
                e_err = 1; e_code = 3; tag = "R8";
            end else begin
                bit found = 0;
                for (int i = 0; i < m_cnt[s]; i++) if (m_q[s][i] == c) found = 1;
                if (found) begin
                    e_err = 1; e_code = 4; tag = "R7";
                end else begin
                    m_q[s][m_cnt[s]] = c; m_cnt[s]++; tag = "R3";
                end
            end
        end else begin
            if (!m_busy[s]) begin
                e_err = 1; e_code = 1; tag = "R9";
            end else if (m_owner[s] != c) begin
                e_err = 1; e_code = 2; tag = "R9";
            end else if (m_cnt[s] > 0) begin
                tag = (m_cnt[s] > 1) ? "R4_R6" : "R4";
                m_owner[s] = m_q[s][0];
                for (int i = 0; i < NC - 1; i++) m_q[s][i] = m_q[s][i+1];
                m_cnt[s]--;
                m_irq[m_owner[s]] = 1; m_stat[m_owner[s]][s] = 1;
            end else begin
                m_busy[s] = 0; tag = "R5";
            end
        end
        if (e_err) begin e_sem = s; e_core = c; end
    endtask

    function automatic void bool_t_dummy();
    endfunction

    task automatic compare_all();
        for (int s = 0; s < NS; s++) begin
            chk(tag, "busy", int'(sem_busy[s]), m_busy[s]);
            if (m_busy[s]) chk(tag, "owner", int'(sem_owner[s*CW +: CW]), m_owner[s]);
        end
        for (int c = 0; c < NC; c++) begin
            chk("R10", "irq", int'(grant_irq[c]), m_irq[c]);
            for (int s = 0; s < NS; s++)
                chk("R10", "status", int'(grant_status[c*NS+s]), m_stat[c][s]);
        end
        chk("R11", "err_valid", int'(err_valid), e_err);
        if (e_err && err_valid) begin
            chk(tag, "err_code", int'(err_code), e_code);
            chk("R11", "err_sem", int'(err_sem), e_sem);
            chk("R11", "err_core", int'(err_core), e_core);
        end
    endtask

    task automatic step(input bit v, input int c, input int s, input bit f,
                        input logic [NC-1:0] clr);
        wr_valid = v; wr_core = CW'(c); wr_sem = SW'(s); wr_free = f; irq_clr = clr;
        model(v, c, s, f, clr);
        @(negedge clk);
        compare_all();
        wr_valid = 1'b0; irq_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_busy[s] = 0; m_owner[s] = 0; m_cnt[s] = 0;
            for (int i = 0; i < NC; i++) m_q[s][i] = 0;
        end
        for (int c = 0; c < NC; c++) begin
            m_irq[c] = 0;
            for (int s = 0; s < NS; s++) m_stat[c][s] = 0;
        end
        e_err = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        compare_all(); // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        compare_all();

        // Directed sweep: every semaphore, every rotation of core order
        for (int s = 0; s < NS; s++) begin
            for (int r = 0; r < NC; r++) begin
                for (int k = 0; k < NC; k++) step(1, (r + k) % NC, s, 0, '0); // R2, R3
                step(1, (r + 1) % NC, s, 0, '0);       // R7 duplicate while waiting
                step(1, r, s, 0, '0);                  // R8 owner requests again
                step(1, (r + 2) % NC, s, 1, '0);       // R9 release by non-owner
                for (int k = 0; k < NC; k++)           // R4, R6 chain; grant beats clear for R10
                    step(1, (r + k) % NC, s, 1, NC'(1 << ((r + k + 1) % NC)));
                step(1, r, s, 1, '0);                  // R9 already free
                step(0, 0, 0, 0, '1);                  // R10 clear all
            end
        end

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int s = int'($urandom_range(NS - 1));
            int c = int'($urandom_range(NC - 1));
            bit f = ($urandom_range(2) == 0);
            bit v = ($urandom_range(9) != 0);
            logic [NC-1:0] clr = ($urandom_range(5) == 0) ? NC'($urandom) : '0;
            if (f && m_busy[s] && $urandom_range(3) != 0) c = m_owner[s];
            step(v, c, s, f, clr);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule